// File: doc/BRIEF.md
# Flash Write-Status Polling Bit Generator

This block is the device-side logic of a byte-wide parallel flash that decides what a host read returns while an internal program or erase operation runs. When nothing runs, a read returns the byte from the cell array. During an operation, a read at an address that is valid for status returns a status byte. Its bit 7 carries the polling flag and bits 6 to 0 read as zero, because the other status bits are not modelled here. A read at an address that is not valid for status returns all ones.

The host starts a program with a single-cycle pulse that carries the target address and bit 7 of the byte being written. It starts an erase with a pulse that carries either a sector mask or a whole-chip flag. An external operation timer reports completion with `op_done`. When a program targets a protected sector, or when every sector selected for erase is protected, the block runs a fixed busy window of its own. That window is about 2 µs for a program and about 100 µs for an erase, and its length in cycles comes from the clock frequency parameter. An erase can be suspended and resumed. While the erase is suspended, one program may run. The address space is split into `SECTORS` equal sectors, and the top `log2(SECTORS)` address bits give the sector number.

The controller has eight states:
- `ST_IDLE` reads array data.
- `ST_PROG` and `ST_PROG_LOCK` cover a normal program and a protected program window.
- `ST_ERASE` and `ST_ERASE_LOCK` cover a normal erase and an all-protected erase window.
- `ST_SUSP` is erase suspended.
- `ST_SUSP_PROG` and `ST_SUSP_LOCK` cover a program issued while suspended, normal or protected.

The transitions are:
- `ST_IDLE` goes to `ST_PROG`/`ST_PROG_LOCK` on a program start and to `ST_ERASE`/`ST_ERASE_LOCK` on an erase start.
- `ST_PROG`→`ST_IDLE` and `ST_ERASE`→`ST_IDLE` happen on `op_done`.
- The lock states return to `ST_IDLE` when their window expires.
- `ST_ERASE`→`ST_SUSP` happens on `susp_req`, and `ST_SUSP`→`ST_ERASE` on `resume_req`.
- `ST_SUSP` goes to `ST_SUSP_PROG`/`ST_SUSP_LOCK` on a program start.
- `ST_SUSP_PROG`→`ST_SUSP` happens on `op_done`, and `ST_SUSP_LOCK`→`ST_SUSP` when its window expires.

Top module: `flash_poll_status`

## Requirements
- R1: `rd_data` resets to 8'hFF. It updates only on a clock edge where `rd_en` is high and otherwise holds. In `ST_IDLE`, a read returns `array_rdata` one cycle later.
- R2: A start pulse takes effect at the clock edge that samples it. A read strobed in the same cycle as an accepted start still returns array data. Every later read returns status.
- R3: During a program, a read at exactly the program address returns bit 7 = inverse of `prog_msb`, with bits 6:0 = 0. After `op_done`, reads return array data again.
- R4: A program whose address lies in a sector with its `sect_prot` bit set holds program status for exactly `CLK_MHZ*PROG_LOCK_US` cycles. After that, reads return array data. `op_done` has no effect during this window.
- R5: During an erase, a read at a valid status address returns 8'h00. After `op_done`, reads return array data.
- R6: An erase whose selected sectors are all protected returns 8'h00 at valid addresses for exactly `CLK_MHZ*ERASE_LOCK_US` cycles, then returns array data.
- R7: The sector number is the top `log2(SECTORS)` bits of an address. For a sector erase (`erase_all`=0), valid addresses are all addresses in sectors set in `erase_mask`, protected ones included. For a chip erase (`erase_all`=1), valid addresses are those in unprotected sectors. If every sector is protected, all sectors count as valid.
- R8: While a program or erase runs (any state except `ST_IDLE` and `ST_SUSP`), a read at an address that is not valid for status returns 8'hFF.
- R9: `susp_req` during an erase moves to suspend. There, a valid erase address reads 8'h80 and any other address reads array data. `resume_req` returns to the erase, which again reads 8'h00.
- R10: A program started during suspend reports status as in R3, or uses the window of R4 when its sector is protected. It returns to suspend when it ends, not to idle.
- R11: A program start takes priority over an erase start in the same cycle. Starts that arrive while an operation runs are ignored, except a program start during suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_go | input | 1 | Program start pulse (final command write) |
| prog_addr | input | ADDR_W | Program target address |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| erase_go | input | 1 | Erase start pulse (final command write) |
| erase_all | input | 1 | 1 = chip erase, 0 = sector erase by mask |
| erase_mask | input | SECTORS | Sectors selected for a sector erase |
| sect_prot | input | SECTORS | Per-sector protect bits |
| susp_req | input | 1 | Erase suspend request pulse |
| resume_req | input | 1 | Erase resume request pulse |
| op_done | input | 1 | Completion pulse from the operation timer |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | 8 | Byte from the cell array at rd_addr |
| rd_data | output | 8 | Registered read result |

## Verification
The embedded properties check the following on every cycle:
- an idle read passes array data through, and `rd_data` holds when no read is strobed;
- the inverted program bit and the zero erase flag appear at hit addresses;
- the suspend flag reads high;
- misses during an operation read all ones;
- a lock window ignores `op_done`;
- a simultaneous program and erase start resolves to the program.

Only the bench scenarios can show that a lock window lasts exactly its cycle count, with its last status read and its first array read one cycle apart. The same holds for the valid-address rules of sector and chip erase under partial protection, the full suspend, program-in-suspend and resume round trip, and a start being ignored while the block is busy.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_PROG       = 3'd1,
        ST_PROG_LOCK  = 3'd2,
        ST_ERASE      = 3'd3,
        ST_ERASE_LOCK = 3'd4,
        ST_SUSP       = 3'd5,
        ST_SUSP_PROG  = 3'd6,
        ST_SUSP_LOCK  = 3'd7
    } fps_state_e;

    localparam logic [7:0] RD_MISS      = 8'hFF;
    localparam logic [7:0] RD_ERASE_RUN = 8'h00;
    localparam logic [7:0] RD_SUSPENDED = 8'h80;

endpackage

// File: rtl/fps_sector_decode.sv
module fps_sector_decode #(
    parameter int SECTORS = 8
) (
    input  logic [$clog2(SECTORS)-1:0] idx,
    output logic [SECTORS-1:0]         onehot
);

    localparam int SW = $clog2(SECTORS);

    for (genvar i = 0; i < SECTORS; i++) begin : g_sel
        assign onehot[i] = (idx == SW'(i));
    end

endmodule

// File: rtl/fps_window_timer.sv
module fps_window_timer #(
    parameter int PROG_CYC  = 250,
    parameter int ERASE_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_short,
    input  logic load_long,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(ERASE_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_long) begin
            cnt <= CW'(ERASE_CYC - 1);
        end else if (load_short) begin
            cnt <= CW'(PROG_CYC - 1);
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_go,
    input  logic       prog_prot,
    input  logic       erase_go,
    input  logic       erase_none,
    input  logic       susp_req,
    input  logic       resume_req,
    input  logic       op_done,
    input  logic       win_expired,
    output fps_state_e state,
    output logic       cap_prog,
    output logic       cap_erase,
    output logic       load_short,
    output logic       load_long,
    output logic       win_run
);

    fps_state_e state_nxt;
    logic       prog_ok;
    logic       erase_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (prog_go) begin
                    state_nxt = prog_prot ? ST_PROG_LOCK : ST_PROG;
                end else if (erase_go) begin
                    state_nxt = erase_none ? ST_ERASE_LOCK : ST_ERASE;
                end
            end
            ST_PROG: begin
                if (op_done) state_nxt = ST_IDLE;
            end
            ST_PROG_LOCK: begin
                if (win_expired) state_nxt = ST_IDLE;
            end
            ST_ERASE: begin
                if (op_done) begin
                    state_nxt = ST_IDLE;
                end else if (susp_req) begin
                    state_nxt = ST_SUSP;
                end
            end
            ST_ERASE_LOCK: begin
                if (win_expired) state_nxt = ST_IDLE;
            end
            ST_SUSP: begin
                if (resume_req) begin
                    state_nxt = ST_ERASE;
                end else if (prog_go) begin
                    state_nxt = prog_prot ? ST_SUSP_LOCK : ST_SUSP_PROG;
                end
            end
            ST_SUSP_PROG: begin
                if (op_done) state_nxt = ST_SUSP;
            end
            ST_SUSP_LOCK: begin
                if (win_expired) state_nxt = ST_SUSP;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        prog_ok    = prog_go && ((state == ST_IDLE) ||
                                 ((state == ST_SUSP) && !resume_req));
        erase_ok   = erase_go && !prog_go && (state == ST_IDLE);
        cap_prog   = prog_ok;
        cap_erase  = erase_ok;
        load_short = prog_ok && prog_prot;
        load_long  = erase_ok && erase_none;
        win_run    = (state == ST_PROG_LOCK) || (state == ST_ERASE_LOCK) ||
                     (state == ST_SUSP_LOCK);
    end

    AST_PROG_BEATS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && prog_go && erase_go) |=> (state == ST_PROG || state == ST_PROG_LOCK)); // R11
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && !op_done && (prog_go || erase_go)) |=> (state == ST_PROG)); // R11
    AST_LOCK_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG_LOCK && !win_expired && op_done) |=> (state == ST_PROG_LOCK)); // R4
    AST_SUSP_PROG_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP_PROG && op_done) |=> (state == ST_SUSP)); // R10

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
    import fps_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int SECTORS       = 8,
    parameter int CLK_MHZ       = 125,
    parameter int PROG_LOCK_US  = 2,
    parameter int ERASE_LOCK_US = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_go,
    input  logic [ADDR_W-1:0]  prog_addr,
    input  logic               prog_msb,
    input  logic               erase_go,
    input  logic               erase_all,
    input  logic [SECTORS-1:0] erase_mask,
    input  logic [SECTORS-1:0] sect_prot,
    input  logic               susp_req,
    input  logic               resume_req,
    input  logic               op_done,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [7:0]         array_rdata,
    output logic [7:0]         rd_data
);

    localparam int SW        = $clog2(SECTORS);
    localparam int PROG_CYC  = CLK_MHZ * PROG_LOCK_US;
    localparam int ERASE_CYC = CLK_MHZ * ERASE_LOCK_US;

    fps_state_e          st;
    logic [SECTORS-1:0]  prog_oh, rd_oh;
    logic [SECTORS-1:0]  sel_mask, eff_mask, vmask;
    logic                prog_prot, erase_none;
    logic                cap_prog, cap_erase, load_short, load_long, win_run;
    logic                win_expired;
    logic [ADDR_W-1:0]   p_addr;
    logic                p_msb;
    logic                hit_prog, hit_erase;
    logic [7:0]          rd_nxt;

    fps_sector_decode #(.SECTORS(SECTORS)) u_prog_dec (
        .idx    (prog_addr[ADDR_W-1 -: SW]),
        .onehot (prog_oh)
    );

    fps_sector_decode #(.SECTORS(SECTORS)) u_rd_dec (
        .idx    (rd_addr[ADDR_W-1 -: SW]),
        .onehot (rd_oh)
    );

    always_comb begin
        prog_prot  = |(prog_oh & sect_prot);
        sel_mask   = erase_all ? {SECTORS{1'b1}} : erase_mask;
        eff_mask   = sel_mask & ~sect_prot;
        erase_none = ~|eff_mask;
    end

    fps_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_go     (prog_go),
        .prog_prot   (prog_prot),
        .erase_go    (erase_go),
        .erase_none  (erase_none),
        .susp_req    (susp_req),
        .resume_req  (resume_req),
        .op_done     (op_done),
        .win_expired (win_expired),
        .state       (st),
        .cap_prog    (cap_prog),
        .cap_erase   (cap_erase),
        .load_short  (load_short),
        .load_long   (load_long),
        .win_run     (win_run)
    );

    fps_window_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_short (load_short),
        .load_long  (load_long),
        .run        (win_run),
        .expired    (win_expired)
    );

    // operation context captured at the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_addr <= '0;
            p_msb  <= 1'b0;
            vmask  <= '0;
        end else begin
            if (cap_prog) begin
                p_addr <= prog_addr;
                p_msb  <= prog_msb;
            end
            if (cap_erase) begin
                vmask <= (erase_all && !erase_none) ? eff_mask : sel_mask;
            end
        end
    end

    // read result selection
    always_comb begin
        hit_prog  = (rd_addr == p_addr);
        hit_erase = |(rd_oh & vmask);
        rd_nxt    = array_rdata;
        unique case (st)
            ST_IDLE:                    rd_nxt = array_rdata;
            ST_PROG, ST_PROG_LOCK,
            ST_SUSP_PROG, ST_SUSP_LOCK: rd_nxt = hit_prog ? {~p_msb, 7'b0} : RD_MISS;
            ST_ERASE, ST_ERASE_LOCK:    rd_nxt = hit_erase ? RD_ERASE_RUN : RD_MISS;
            ST_SUSP:                    rd_nxt = hit_erase ? RD_SUSPENDED : array_rdata;
            default:                    rd_nxt = RD_MISS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= RD_MISS;
        end else if (rd_en) begin
            rd_data <= rd_nxt;
        end
    end

    AST_IDLE_PASSES_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_IDLE) |=> (rd_data == $past(array_rdata))); // R1
    AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R1
    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && (prog_go || erase_go)) |=> (st != ST_IDLE)); // R2
    AST_PROG_INVERTS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_PROG || st == ST_SUSP_PROG) && rd_addr == p_addr)
        |=> (rd_data[7] != $past(p_msb) && rd_data[6:0] == 7'd0)); // R3
    AST_ERASE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_ERASE || st == ST_ERASE_LOCK) && hit_erase) |=> (rd_data == 8'h00)); // R5
    AST_MISS_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (st == ST_ERASE || st == ST_ERASE_LOCK) && !hit_erase) |=> (rd_data == 8'hFF)); // R8
    AST_SUSP_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_SUSP && hit_erase) |=> rd_data[7]); // R9
    AST_LOCK_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
        (win_run && win_expired) |=> (st == ST_IDLE || st == ST_SUSP)); // R6

endmodule

// File: tb/tb_flash_poll_status.sv
module tb_flash_poll_status;

    localparam int AW        = 19;
    localparam int NS        = 8;
    localparam int PROG_WIN  = 125 * 2;
    localparam int ERASE_WIN = 125 * 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_go = 1'b0, prog_msb = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic          erase_go = 1'b0, erase_all = 1'b0;
    logic [NS-1:0] erase_mask = '0, sect_prot = '0;
    logic          susp_req = 1'b0, resume_req = 1'b0, op_done = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    array_rdata;
    logic [7:0]    rd_data;

    logic          ov_valid = 1'b0;
    logic [AW-1:0] ov_addr = '0;
    logic [7:0]    ov_val = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic pend = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    assign array_rdata = (ov_valid && rd_addr == ov_addr) ? ov_val : (rd_addr[7:0] ^ 8'h5A);

    flash_poll_status dut (
        .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_addr(prog_addr),
        .prog_msb(prog_msb), .erase_go(erase_go), .erase_all(erase_all),
        .erase_mask(erase_mask), .sect_prot(sect_prot), .susp_req(susp_req),
        .resume_req(resume_req), .op_done(op_done), .rd_en(rd_en),
        .rd_addr(rd_addr), .array_rdata(array_rdata), .rd_data(rd_data)
    );

    function automatic logic [7:0] arr(input logic [AW-1:0] a);
        return (ov_valid && a == ov_addr) ? ov_val : (a[7:0] ^ 8'h5A);
    endfunction

    function automatic logic [AW-1:0] sa(input int s, input int off);
        return {3'(s), 16'(off)};
    endfunction

    // monitor: pops one expectation per completed read
    always @(posedge clk) pend <= rd_en;

    always @(negedge clk) begin
        if (pend) begin
            logic [7:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard underflow: got %02h expected none", rd_data);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        rd_addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_prog(input logic [AW-1:0] a, input logic m);
        prog_addr = a; prog_msb = m; prog_go = 1'b1;
        @(negedge clk);
        prog_go = 1'b0;
    endtask

    task automatic t_erase(input logic all, input logic [NS-1:0] m);
        erase_all = all; erase_mask = m; erase_go = 1'b1;
        @(negedge clk);
        erase_go = 1'b0;
    endtask

    task automatic t_done;
        op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    endtask

    task automatic t_susp;
        susp_req = 1'b1; @(negedge clk); susp_req = 1'b0;
    endtask

    task automatic t_resume;
        resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rd_data !== 8'hFF) begin
            fails++;
            $display("FAIL R1 reset: got %02h expected ff", rd_data);
        end

        do_read(sa(2, 16), arr(sa(2, 16)), "R1 idle read");

        // R2: read in the same cycle as the program start sees array data
        prog_addr = sa(1, 32); prog_msb = 1'b0; prog_go = 1'b1;
        rd_addr = sa(1, 32); rd_en = 1'b1;
        exp_q.push_back(arr(sa(1, 32))); tag_q.push_back("R2 same-cycle read");
        @(negedge clk);
        prog_go = 1'b0; rd_en = 1'b0;
        do_read(sa(1, 32), 8'h80, "R3 program msb0");
        do_read(sa(1, 33), 8'hFF, "R8 program miss");
        do_read(sa(4, 0),  8'hFF, "R8 program other sector");
        t_done;
        ov_valid = 1'b1; ov_addr = sa(1, 32); ov_val = 8'h3C;
        do_read(sa(1, 32), 8'h3C, "R3 after completion");

        // R3 msb 1, R11 erase ignored while programming
        t_prog(sa(6, 5), 1'b1);
        do_read(sa(6, 5), 8'h00, "R3 program msb1");
        t_erase(1'b0, 8'h40);
        do_read(sa(6, 9), 8'hFF, "R11 erase ignored while busy");
        do_read(sa(6, 5), 8'h00, "R11 program status kept");
        t_done;
        do_read(sa(6, 5), arr(sa(6, 5)), "R3 array after msb1");

        // R11 priority
        prog_addr = sa(0, 7); prog_msb = 1'b1; prog_go = 1'b1;
        erase_all = 1'b1; erase_go = 1'b1;
        @(negedge clk);
        prog_go = 1'b0; erase_go = 1'b0; erase_all = 1'b0;
        do_read(sa(3, 0), 8'hFF, "R11 program wins over erase");
        do_read(sa(0, 7), 8'h00, "R11 program status");
        t_done;

        // R4 protected program window
        sect_prot = 8'h20;
        t_prog(sa(5, 3), 1'b0);
        t_done;
        repeat (PROG_WIN - 2) @(negedge clk);
        do_read(sa(5, 3), 8'h80, "R4 last window cycle");
        do_read(sa(5, 3), arr(sa(5, 3)), "R4 first cycle after window");

        // R5, R9, R10 erase, suspend, program in suspend
        t_erase(1'b0, 8'h06);
        do_read(sa(1, 0),   8'h00, "R5 erase selected sector");
        do_read(sa(2, 255), 8'h00, "R7 second selected sector");
        do_read(sa(3, 0),   8'hFF, "R8 erase miss");
        t_susp;
        do_read(sa(1, 0), 8'h80, "R9 suspended flag");
        do_read(sa(3, 4), arr(sa(3, 4)), "R9 suspended array read");
        t_prog(sa(3, 4), 1'b0);
        do_read(sa(3, 4), 8'h80, "R10 program in suspend");
        do_read(sa(1, 0), 8'hFF, "R10 miss during suspend program");
        t_done;
        do_read(sa(1, 0), 8'h80, "R10 back to suspend");
        t_prog(sa(5, 1), 1'b1);
        do_read(sa(5, 1), 8'h00, "R10 protected program in suspend");
        repeat (PROG_WIN - 2) @(negedge clk);
        do_read(sa(5, 1), 8'h00, "R10 protected window last cycle");
        do_read(sa(1, 0), 8'h80, "R10 window returns to suspend");
        t_resume;
        do_read(sa(1, 0), 8'h00, "R9 resumed erase");
        t_done;
        do_read(sa(1, 0), arr(sa(1, 0)), "R5 array after erase");

        // R6 all-protected erase window
        t_erase(1'b0, 8'h20);
        do_read(sa(5, 0), 8'h00, "R6 protected erase status");
        do_read(sa(0, 0), 8'hFF, "R8 protected erase miss");
        t_done;
        repeat (ERASE_WIN - 4) @(negedge clk);
        do_read(sa(5, 0), 8'h00, "R6 last window cycle");
        do_read(sa(5, 0), arr(sa(5, 0)), "R6 first cycle after window");

        // R7 chip erase with a protected sector
        t_erase(1'b1, 8'h00);
        do_read(sa(5, 0), 8'hFF, "R7 chip erase skips protected");
        do_read(sa(7, 0), 8'h00, "R7 chip erase unprotected");
        t_done;
        do_read(sa(7, 0), arr(sa(7, 0)), "R5 array after chip erase");

        // R7 sector erase includes a selected protected sector
        t_erase(1'b0, 8'h24);
        do_read(sa(5, 0), 8'h00, "R7 selected protected sector valid");
        do_read(sa(2, 0), 8'h00, "R7 selected sector valid");
        t_done;

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule